// File: doc/BRIEF.md
# Multicart Outer Bank Register File

This block sits beside a cartridge bank-switching unit and adds the outer bank bits that a multi-game cartridge needs. The CPU writes into the 0x6000–0x7FFF window, and each write lands in one of four 8-bit outer registers. A 2-bit pointer picks the register and steps round-robin after every accepted write. Software can set one bit to freeze the whole register set, so that a game selected from a menu cannot later change its own outer bank.

The inner bank unit supplies an inner program bank number and an inner pattern bank number. This block combines them with the outer registers to produce the final bank numbers. The pattern bank is limited by a mask whose width is a programmable power of two, and it is then based at an outer offset. The program bank has a programmable set of bits cleared, and it is then based at an outer block. Both outputs are combinational from the inner inputs and the held registers, so they follow an accepted write with no extra step. The reset input is asynchronous when asserted, and its release is synchronised inside the block.

Top module: `mcob_outer_bank`

## Requirements
- R1: A write strobe with an address in 0x6000–0x7FFF (address bits 15:13 equal 3'b011) stores the data byte into the register the pointer selects. The pointer then moves to the next register, wrapping from register 3 back to register 0. The first write after reset goes to register 0.
- R2: A write strobe with an address outside 0x6000–0x7FFF changes no register and does not move the pointer.
- R3: While bit 6 of register 3 is 1, every write is ignored and the pointer holds. The write that sets the bit is itself accepted.
- R4: The low 8 bits of the pattern output are the inner pattern bank ANDed with the mask (2^(k+1))−1, where k is register 2 bits 2:0, and then ORed with register 0.
- R5: Pattern output bit 8 equals register 2 bit 4.
- R6: The program output is the inner program bank with the bits set in register 3 bits 5:0 cleared, then ORed with register 1.
- R7: Reset clears all four registers and the pointer. Just after reset, the program output equals the inner program bank and the pattern output equals inner pattern bit 0 alone.
- R8: Both outputs track the inner bank inputs combinationally. After an accepted write, they show the new register value once the clock edge that accepts the write has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| cpu_addr | input | 16 | CPU address of the write |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| inner_prg | input | 8 | Inner program bank from the bank unit |
| inner_chr | input | 8 | Inner pattern bank from the bank unit |
| prg_bank | output | 8 | Final program bank number |
| chr_bank | output | 9 | Final pattern bank number |

## Verification
The pointer is not visible at the ports. A pointer that slips or fails to wrap therefore shows up as a byte in the wrong register, and that error becomes visible as a wrong mask or base on the outputs right after the following writes. A lock that fails to hold, or a stray write that gets accepted, corrupts an output in the cycle after that write. The bench sweeps every inner bank value under each of the eight mask widths and each lock state, so a masking or base error shows up as soon as the register that holds it is loaded.

// File: rtl/mcob_pkg.sv
package mcob_pkg;
  // address window decode: bits 15:13 of a write address
  localparam logic [2:0] WIN_TAG     = 3'b011;
  localparam int         ADDR_W      = 16;
  // register roles inside the set
  localparam int         CHR_BASE_IX = 0;
  localparam int         PRG_BASE_IX = 1;
  localparam int         CHR_CTL_IX  = 2;
  localparam int         PRG_CTL_IX  = 3;
  // field positions within the control registers
  localparam int         LOCK_BIT    = 6;
  localparam int         PRG_CLR_W   = 6;
  localparam int         SIZE_W      = 3;
  localparam int         CHR_HI_BIT  = 4;
endpackage

// File: rtl/mcob_reset_sync.sv
module mcob_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/mcob_wr_ctrl.sv
module mcob_wr_ctrl #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 16,
  localparam int PTR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_wr,
  input  logic                locked,
  output logic [NUM_REGS-1:0] wr_sel
);
  import mcob_pkg::*;

  logic             in_window;
  logic             accept;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  assign in_window = (cpu_addr[ADDR_W-1 -: 3] == WIN_TAG);
  assign accept    = cpu_wr && in_window && !locked;

  always_comb begin
    ptr_en = accept;
    if (ptr_q == PTR_W'(NUM_REGS - 1)) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel[g] = accept && (ptr_q == PTR_W'(g));
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ptr_q != PTR_W'(NUM_REGS - 1)) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R1
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ptr_q == PTR_W'(NUM_REGS - 1)) |=> (ptr_q == '0)); // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R1
  AST_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !in_window) |=> $stable(ptr_q)); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ptr_q)); // R3
  AST_PTR_RESET: assert property (@(posedge clk)
    !rst_n |-> (ptr_q == '0)); // R7
endmodule

// File: rtl/mcob_regfile.sv
module mcob_regfile #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS-1:0]       wr_sel,
  input  logic [REG_W-1:0]          wr_data,
  output logic [NUM_REGS*REG_W-1:0] regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] d;
    logic             en;

    always_comb begin
      en = wr_sel[g];
      d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign regs_flat[g*REG_W +: REG_W] = q;
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == '0) |=> $stable(regs_flat)); // R2
  AST_REGS_RESET: assert property (@(posedge clk)
    !rst_n |-> (regs_flat == '0)); // R7
endmodule

// File: rtl/mcob_prg_map.sv
module mcob_prg_map #(
  parameter int PRG_W = 8,
  parameter int CLR_W = 6
) (
  input  logic [PRG_W-1:0] inner,
  input  logic [CLR_W-1:0] clr_bits,
  input  logic [PRG_W-1:0] base,
  output logic [PRG_W-1:0] bank
);
  logic [PRG_W-1:0] keep;

  always_comb begin
    keep = '1;
    for (int i = 0; i < PRG_W; i++) begin
      if (i < CLR_W) keep[i] = !clr_bits[i];
    end
    bank = (inner & keep) | base;
  end
endmodule

// File: rtl/mcob_chr_map.sv
module mcob_chr_map #(
  parameter int CHR_W  = 8,
  parameter int SIZE_W = 3,
  localparam int OUT_W = CHR_W + 1
) (
  input  logic [CHR_W-1:0]  inner,
  input  logic [SIZE_W-1:0] size_sel,
  input  logic [CHR_W-1:0]  base,
  input  logic              hi_bit,
  output logic [OUT_W-1:0]  bank
);
  logic [CHR_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < CHR_W; i++) begin
      mask[i] = (i <= int'(size_sel));
    end
    bank = {hi_bit, (inner & mask) | base};
  end
endmodule

// File: rtl/mcob_outer_bank.sv
module mcob_outer_bank #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int PRG_W    = 8,
  parameter int CHR_W    = 8,
  localparam int CHR_OUT_W = CHR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic                  cpu_wr,
  input  logic [REG_W-1:0]      cpu_wdata,
  input  logic [PRG_W-1:0]      inner_prg,
  input  logic [CHR_W-1:0]      inner_chr,
  output logic [PRG_W-1:0]      prg_bank,
  output logic [CHR_OUT_W-1:0]  chr_bank
);
  import mcob_pkg::*;

  logic                      rst_sync_n;
  logic [NUM_REGS-1:0]       wr_sel;
  logic [NUM_REGS*REG_W-1:0] regs_flat;
  logic [REG_W-1:0]          r_chr_base;
  logic [REG_W-1:0]          r_prg_base;
  logic [REG_W-1:0]          r_chr_ctl;
  logic [REG_W-1:0]          r_prg_ctl;
  logic                      locked;

  mcob_reset_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  mcob_wr_ctrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .locked   (locked),
    .wr_sel   (wr_sel)
  );

  mcob_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_sel    (wr_sel),
    .wr_data   (cpu_wdata),
    .regs_flat (regs_flat)
  );

  assign r_chr_base = regs_flat[CHR_BASE_IX*REG_W +: REG_W];
  assign r_prg_base = regs_flat[PRG_BASE_IX*REG_W +: REG_W];
  assign r_chr_ctl  = regs_flat[CHR_CTL_IX*REG_W +: REG_W];
  assign r_prg_ctl  = regs_flat[PRG_CTL_IX*REG_W +: REG_W];
  assign locked     = r_prg_ctl[LOCK_BIT];

  mcob_prg_map #(.PRG_W(PRG_W), .CLR_W(PRG_CLR_W)) u_prg (
    .inner    (inner_prg),
    .clr_bits (r_prg_ctl[PRG_CLR_W-1:0]),
    .base     (r_prg_base[PRG_W-1:0]),
    .bank     (prg_bank)
  );

  mcob_chr_map #(.CHR_W(CHR_W), .SIZE_W(SIZE_W)) u_chr (
    .inner    (inner_chr),
    .size_sel (r_chr_ctl[SIZE_W-1:0]),
    .base     (r_chr_base[CHR_W-1:0]),
    .hi_bit   (r_chr_ctl[CHR_HI_BIT]),
    .bank     (chr_bank)
  );

  AST_CHR_BASE_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((chr_bank[CHR_W-1:0] & r_chr_base[CHR_W-1:0]) == r_chr_base[CHR_W-1:0])); // R4
  AST_CHR_LSB_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chr_bank[0] == (inner_chr[0] | r_chr_base[0]))); // R4
  AST_PRG_BASE_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((prg_bank & r_prg_base[PRG_W-1:0]) == r_prg_base[PRG_W-1:0])); // R6
  AST_PRG_CLEARED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((prg_bank[PRG_CLR_W-1:0] & r_prg_ctl[PRG_CLR_W-1:0] & ~r_prg_base[PRG_CLR_W-1:0]) == '0)); // R6
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |=> $stable(regs_flat)); // R3
endmodule

// File: tb/mcob_outer_bank_test.sv
module mcob_outer_bank_test;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  inner_prg;
  logic [7:0]  inner_chr;
  logic [7:0]  prg_bank;
  logic [8:0]  chr_bank;

  int checks;
  int fails;

  logic [7:0] m_reg [4];
  int         m_ptr;

  mcob_outer_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .inner_prg (inner_prg),
    .inner_chr (inner_chr),
    .prg_bank  (prg_bank),
    .chr_bank  (chr_bank)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [7:0] exp_prg(logic [7:0] inn);
    return (inn & ~{2'b00, m_reg[3][5:0]}) | m_reg[1];
  endfunction

  function automatic logic [8:0] exp_chr(logic [7:0] inn);
    logic [7:0] mask;
    mask = 8'((9'd1 << (m_reg[2][2:0] + 1)) - 9'd1);
    return {m_reg[2][4], (inn & mask) | m_reg[0]};
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // sweep every inner value; outputs are combinational
  task automatic sweep(string tprg, string tchr);
    for (int v = 0; v < 256; v++) begin
      inner_prg = 8'(v);
      inner_chr = 8'(255 - v);
      #1;
      check(tprg, {1'b0, prg_bank}, {1'b0, exp_prg(8'(v))});
      check(tchr, chr_bank, exp_chr(8'(255 - v)));
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr    = 1'b0;
    if (a[15:13] == 3'b011 && !m_reg[3][6]) begin
      m_reg[m_ptr] = d;
      m_ptr = (m_ptr + 1) % 4;
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    m_ptr = 0;
  endtask

  initial begin
    checks = 0;
    fails = 0;
    cpu_addr = 16'h0000;
    cpu_wr = 1'b0;
    cpu_wdata = 8'h00;
    inner_prg = 8'h00;
    inner_chr = 8'h00;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    do_reset();

    // R7: reset state, prg passes through, chr keeps bit 0 only
    sweep("R7_prg", "R7_chr");

    // R1 / R8: four writes fill registers 0..3 in order
    cpu_write(16'h6000, 8'h30);
    cpu_write(16'h7FFF, 8'h80);
    cpu_write(16'h6123, 8'h12);
    cpu_write(16'h7000, 8'h0F);
    sweep("R1_R6_prg", "R1_R4_R5_chr");

    // R4 / R5 / R6: every mask width, with varying bases and clear bits
    for (int k = 0; k < 8; k++) begin
      cpu_write(16'h6000 + 16'(k), 8'(k * 3) & 8'h01);
      cpu_write(16'h6800, 8'(k << 5));
      cpu_write(16'h7400, 8'(k) | ((k % 2 == 1) ? 8'h10 : 8'h00));
      cpu_write(16'h7C00, 8'((k * 11) & 8'h3F) | 8'h80);
      sweep("R6_prg", "R4_R5_chr");
    end

    // R2: writes outside the window leave registers and pointer alone
    cpu_write(16'h5FFF, 8'hFF);
    cpu_write(16'h8000, 8'hFF);
    cpu_write(16'hE000, 8'hFF);
    sweep("R2_prg", "R2_chr");
    // pointer unmoved: next window write must land in register 0
    cpu_write(16'h6000, 8'h04);
    sweep("R2_R1_prg", "R2_R1_chr");

    // R3: fill registers 1..3, register 3 sets the lock
    cpu_write(16'h6000, 8'h40);
    cpu_write(16'h6000, 8'h13);
    cpu_write(16'h6000, 8'h4C);
    sweep("R3_prg", "R3_chr");
    cpu_write(16'h6000, 8'hAA);
    cpu_write(16'h7000, 8'h55);
    cpu_write(16'h6FFF, 8'h00);
    cpu_write(16'h7FFF, 8'h07);
    cpu_write(16'h6000, 8'h00);
    sweep("R3_locked_prg", "R3_locked_chr");

    // R7: reset clears the lock and every register
    do_reset();
    sweep("R7_again_prg", "R7_again_chr");
    cpu_write(16'h6000, 8'h21);
    sweep("R7_R1_prg", "R7_R1_chr");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule